// File: doc/BRIEF.md
# Two-Level Virtual Address Translator

This block turns a 32-bit virtual address into a physical address by walking descriptor tables held in memory. The two upper bits of the address pick one of four table origins, which arrive on an input bus from registers kept elsewhere. The next thirteen bits index a two-word segment descriptor. A flag in that descriptor decides how the rest of the walk goes. A contiguous segment adds the 17-bit low field to a base address. A paged segment fetches a page entry and puts the frame number in front of an 11-bit in-page offset.

A client raises `req_i` with an address while the block is idle. The block then reads memory through a request/acknowledge port, one word at a time. It finishes with a single-cycle `valid_o` pulse. On that pulse it gives either the physical address or a fault with a code and the virtual address that caused it. While a walk is in progress, new requests are ignored.

Top module: `addr_xlate`

## Requirements
- R1: After reset the block is idle, with `busy_o`, `mem_req_o`, `valid_o` and `fault_o` low and `paddr_o`, `fault_code_o` and `fault_addr_o` at zero.
- R2: An accepted request first reads the descriptor word at `base[vaddr[31:30]] + 8*vaddr[29:17]`. When the walk continues, it next reads `+4` from that address. Base n sits at bits `[32n+31:32n]` of `sect_base_i`.
- R3: Descriptor word 0 with bit 31 clear marks an absent segment. The walk ends after that one read with fault code 1.
- R4: For both kinds of segment, a low field `vaddr[16:0]` greater than descriptor word 0 bits `[16:0]` ends the walk after one read with fault code 2. A field equal to the limit is allowed.
- R5: Descriptor word 0 with bit 30 clear marks a contiguous segment. The result is word 1 plus `vaddr[16:0]`, after exactly two reads.
- R6: Descriptor word 0 with bit 30 set marks a paged segment. The third read is at word 1 + `4*vaddr[16:11]`. A page entry with bit 0 clear gives fault code 3.
- R7: A present page entry gives the physical address `{pte[31:11], vaddr[10:0]}`, after exactly three reads.
- R8: `valid_o` is high for one cycle, in the cycle after the acknowledge of the last read. When `fault_o` is high with it, `fault_addr_o` holds the virtual address of that walk.
- R9: A request raised while the block is busy has no effect. Only one completion appears, and it carries the result of the first address. No further read follows it.
- R10: `mem_req_o` and `mem_addr_o` stay constant from the cycle a read is raised until the cycle `mem_ack_i` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Translation request; taken only when idle |
| vaddr_i | input | 32 | Virtual address to translate |
| sect_base_i | input | 128 | Four table origins, origin n in bits [32n+31:32n] |
| busy_o | output | 1 | A walk is in progress |
| valid_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 1 | The completion is a fault |
| fault_code_o | output | 2 | 1 segment absent, 2 limit exceeded, 3 page absent |
| paddr_o | output | 32 | Physical address of the last good walk |
| fault_addr_o | output | 32 | Virtual address of the last faulting walk |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 32 | Memory read address |
| mem_ack_i | input | 1 | Memory read acknowledge; data valid with it |
| mem_rdata_i | input | 32 | Memory read data |

## Verification
The assertions assume that memory raises `mem_ack_i` only while `mem_req_o` is high, and that the read data is valid in the acknowledge cycle. The bench's memory responder acknowledges only an outstanding read, after a random wait of zero to two cycles. It returns data from a hash of the address, or from directed overrides. Busy-time requests are sent only during walks that need at least two reads. This keeps the stray request from arriving just as the walk returns to idle.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  typedef enum logic [1:0] {
    FLT_NONE        = 2'd0,
    FLT_SEG_ABSENT  = 2'd1,
    FLT_LIMIT       = 2'd2,
    FLT_PAGE_ABSENT = 2'd3
  } flt_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DESC0 = 2'd1,
    ST_DESC1 = 2'd2,
    ST_PTE   = 2'd3
  } st_e;
endpackage

// File: rtl/xlate_fault_chk.sv
module xlate_fault_chk
  import xlate_pkg::*;
#(
  parameter int OFF_W = 17
) (
  input  st_e              st_i,
  input  logic             seg_present_i,
  input  logic [OFF_W-1:0] limit_i,
  input  logic [OFF_W-1:0] offset_i,
  input  logic             pte_present_i,
  output flt_e             code_o
);
  always_comb begin
    code_o = FLT_NONE;
    unique case (st_i)
      ST_DESC0: begin
        if (!seg_present_i)          code_o = FLT_SEG_ABSENT;
        else if (offset_i > limit_i) code_o = FLT_LIMIT;
      end
      ST_PTE: if (!pte_present_i) code_o = FLT_PAGE_ABSENT;
      default: code_o = FLT_NONE;
    endcase
  end
endmodule

// File: rtl/xlate_addr_gen.sv
module xlate_addr_gen
  import xlate_pkg::*;
#(
  parameter int VA_W   = 32,
  parameter int SID_W  = 2,
  parameter int SEG_W  = 13,
  parameter int PSEL_W = 6,
  parameter int POFF_W = 11
) (
  input  logic [(1<<SID_W)*VA_W-1:0] sect_base_i,
  input  logic [VA_W-1:0]            vaddr_i,
  input  logic [VA_W-1:0]            tbl_base_i,
  input  st_e                        st_i,
  input  logic [VA_W-1:0]            rdata_i,
  output logic [VA_W-1:0]            mem_addr_o,
  output logic [VA_W-1:0]            phys_contig_o,
  output logic [VA_W-1:0]            phys_paged_o
);
  localparam int OFF_W   = PSEL_W + POFF_W;
  localparam int N_SECT  = 1 << SID_W;
  localparam int DESC_SH = 3;  // two words per descriptor
  localparam int PTE_SH  = 2;  // one word per page entry

  logic [VA_W-1:0] base_arr [N_SECT];

  for (genvar g = 0; g < N_SECT; g++) begin : g_base
    assign base_arr[g] = sect_base_i[g*VA_W +: VA_W];
  end

  logic [SID_W-1:0]  sid;
  logic [SEG_W-1:0]  seg;
  logic [OFF_W-1:0]  off;
  logic [PSEL_W-1:0] psel;
  logic [POFF_W-1:0] poff;
  logic [VA_W-1:0]   desc_addr;
  logic [VA_W-1:0]   pte_addr;

  assign sid  = vaddr_i[VA_W-1 -: SID_W];
  assign seg  = vaddr_i[OFF_W +: SEG_W];
  assign off  = vaddr_i[OFF_W-1:0];
  assign psel = vaddr_i[POFF_W +: PSEL_W];
  assign poff = vaddr_i[POFF_W-1:0];

  assign desc_addr = base_arr[sid] + (VA_W'(seg) << DESC_SH);
  assign pte_addr  = tbl_base_i + (VA_W'(psel) << PTE_SH);

  always_comb begin
    unique case (st_i)
      ST_DESC0: mem_addr_o = desc_addr;
      ST_DESC1: mem_addr_o = desc_addr + VA_W'(4);
      ST_PTE:   mem_addr_o = pte_addr;
      default:  mem_addr_o = '0;
    endcase
  end

  assign phys_contig_o = rdata_i + VA_W'(off);
  assign phys_paged_o  = {rdata_i[VA_W-1:POFF_W], poff};
endmodule

// File: rtl/xlate_walk_fsm.sv
module xlate_walk_fsm
  import xlate_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic mem_ack_i,
  input  logic paged_i,
  input  flt_e flt_i,
  output st_e  st_o,
  output logic accept_o,
  output logic cap_tbl_o,
  output logic fin_o,
  output logic fin_flt_o
);
  st_e  st_q, st_d;
  logic paged_q;

  always_comb begin
    st_d      = st_q;
    accept_o  = 1'b0;
    cap_tbl_o = 1'b0;
    fin_o     = 1'b0;
    fin_flt_o = 1'b0;
    unique case (st_q)
      ST_IDLE: if (req_i) begin
        accept_o = 1'b1;
        st_d     = ST_DESC0;
      end
      ST_DESC0: if (mem_ack_i) begin
        if (flt_i != FLT_NONE) begin
          fin_o     = 1'b1;
          fin_flt_o = 1'b1;
          st_d      = ST_IDLE;
        end else begin
          st_d = ST_DESC1;
        end
      end
      ST_DESC1: if (mem_ack_i) begin
        if (paged_q) begin
          cap_tbl_o = 1'b1;
          st_d      = ST_PTE;
        end else begin
          fin_o = 1'b1;
          st_d  = ST_IDLE;
        end
      end
      ST_PTE: if (mem_ack_i) begin
        fin_o     = 1'b1;
        fin_flt_o = (flt_i != FLT_NONE);
        st_d      = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      paged_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_DESC0 && mem_ack_i) paged_q <= paged_i;
    end
  end

  assign st_o = st_q;

  // R7: a page entry is read only for a segment flagged as paged
  a_r7_pte_needs_paged: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DESC1 && mem_ack_i && !paged_q) |=> (st_q != ST_PTE));
endmodule

// File: rtl/addr_xlate.sv
module addr_xlate
  import xlate_pkg::*;
#(
  parameter int VA_W   = 32,
  parameter int SID_W  = 2,
  parameter int SEG_W  = 13,
  parameter int PSEL_W = 6,
  parameter int POFF_W = 11
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        req_i,
  input  logic [VA_W-1:0]             vaddr_i,
  input  logic [(1<<SID_W)*VA_W-1:0]  sect_base_i,
  output logic                        busy_o,
  output logic                        valid_o,
  output logic                        fault_o,
  output logic [1:0]                  fault_code_o,
  output logic [VA_W-1:0]             paddr_o,
  output logic [VA_W-1:0]             fault_addr_o,
  output logic                        mem_req_o,
  output logic [VA_W-1:0]             mem_addr_o,
  input  logic                        mem_ack_i,
  input  logic [VA_W-1:0]             mem_rdata_i
);
  localparam int OFF_W = PSEL_W + POFF_W;

  st_e             st;
  flt_e            flt;
  logic            accept, cap_tbl, fin, fin_flt;
  logic [VA_W-1:0] vaddr_q, tbl_q;
  logic [VA_W-1:0] phys_contig, phys_paged;
  logic            valid_q, fault_q;
  logic [1:0]      code_q;
  logic [VA_W-1:0] paddr_q, faddr_q;

  xlate_walk_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .mem_ack_i (mem_ack_i),
    .paged_i   (mem_rdata_i[VA_W-2]),
    .flt_i     (flt),
    .st_o      (st),
    .accept_o  (accept),
    .cap_tbl_o (cap_tbl),
    .fin_o     (fin),
    .fin_flt_o (fin_flt)
  );

  xlate_fault_chk #(.OFF_W(OFF_W)) u_chk (
    .st_i          (st),
    .seg_present_i (mem_rdata_i[VA_W-1]),
    .limit_i       (mem_rdata_i[OFF_W-1:0]),
    .offset_i      (vaddr_q[OFF_W-1:0]),
    .pte_present_i (mem_rdata_i[0]),
    .code_o        (flt)
  );

  xlate_addr_gen #(
    .VA_W(VA_W), .SID_W(SID_W), .SEG_W(SEG_W), .PSEL_W(PSEL_W), .POFF_W(POFF_W)
  ) u_gen (
    .sect_base_i   (sect_base_i),
    .vaddr_i       (vaddr_q),
    .tbl_base_i    (tbl_q),
    .st_i          (st),
    .rdata_i       (mem_rdata_i),
    .mem_addr_o    (mem_addr_o),
    .phys_contig_o (phys_contig),
    .phys_paged_o  (phys_paged)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vaddr_q <= '0;
      tbl_q   <= '0;
      valid_q <= 1'b0;
      fault_q <= 1'b0;
      code_q  <= '0;
      paddr_q <= '0;
      faddr_q <= '0;
    end else begin
      valid_q <= fin;
      if (accept)  vaddr_q <= vaddr_i;
      if (cap_tbl) tbl_q   <= mem_rdata_i;
      if (fin) begin
        fault_q <= fin_flt;
        code_q  <= fin_flt ? flt : FLT_NONE;
        if (fin_flt) faddr_q <= vaddr_q;
        else         paddr_q <= (st == ST_PTE) ? phys_paged : phys_contig;
      end
    end
  end

  assign busy_o       = (st != ST_IDLE);
  assign mem_req_o    = (st != ST_IDLE);
  assign valid_o      = valid_q;
  assign fault_o      = valid_q & fault_q;
  assign fault_code_o = code_q;
  assign paddr_o      = paddr_q;
  assign fault_addr_o = faddr_q;

  a_r10_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));

  a_r8_valid_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(mem_req_o && mem_ack_i));

  a_r8_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  a_r3_fault_coded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (fault_code_o != 2'd0));

  a_r9_busy_holds_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(vaddr_q));

  a_r2_accept_reads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o) |=> mem_req_o);
endmodule

// File: tb/tb_addr_xlate.sv
module tb_addr_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_i = 1'b0;
  logic [31:0] vaddr_i = '0;
  logic [31:0] sb [4];
  logic        busy_o, valid_o, fault_o, mem_req_o;
  logic [1:0]  fault_code_o;
  logic [31:0] paddr_o, fault_addr_o, mem_addr_o;
  logic        mem_ack_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int nrd    = 0;
  int last_ack_cyc = 0;
  int wait_cnt = 0;
  logic [31:0] rd_log [4];
  logic [31:0] ovr [logic [31:0]];

  always #2.5 clk = ~clk;

  addr_xlate dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req_i), .vaddr_i(vaddr_i),
    .sect_base_i({sb[3], sb[2], sb[1], sb[0]}),
    .busy_o(busy_o), .valid_o(valid_o), .fault_o(fault_o),
    .fault_code_o(fault_code_o), .paddr_o(paddr_o), .fault_addr_o(fault_addr_o),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i)
  );

  function automatic logic [31:0] mem_rd(input logic [31:0] a);
    logic [31:0] h;
    if (ovr.exists(a)) return ovr[a];
    h = a * 32'h9E37_79B1;
    h = h ^ (h >> 15);
    h = h * 32'h85EB_CA6B;
    h = h ^ (h >> 13);
    return h;
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  // memory responder: random 0..2 cycle wait, data from hash or overrides
  always @(negedge clk) begin
    if (rst_n && mem_req_o) begin
      if (wait_cnt == 0) begin
        mem_ack_i   = 1'b1;
        mem_rdata_i = mem_rd(mem_addr_o);
        if (nrd < 4) rd_log[nrd] = mem_addr_o;
        nrd = nrd + 1;
        last_ack_cyc = cyc;
        wait_cnt = int'($urandom % 3);
      end else begin
        mem_ack_i = 1'b0;
        wait_cnt  = wait_cnt - 1;
      end
    end else begin
      mem_ack_i = 1'b0;
    end
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", r, act, exp);
    end
  endtask

  task automatic model(input logic [31:0] v, output logic f, output logic [1:0] code,
                       output logic [31:0] pa, output int n, output logic [31:0] ea [4]);
    logic [31:0] d, w0, w1, pa_pte, pte;
    d = sb[v[31:30]] + {16'd0, v[29:17], 3'b000};
    w0 = mem_rd(d);
    ea[0] = d; ea[1] = d + 32'd4; ea[2] = '0; ea[3] = '0;
    f = 1'b0; code = 2'd0; pa = '0;
    if (!w0[31]) begin f = 1'b1; code = 2'd1; n = 1; end
    else if (v[16:0] > w0[16:0]) begin f = 1'b1; code = 2'd2; n = 1; end
    else begin
      w1 = mem_rd(d + 32'd4);
      if (!w0[30]) begin pa = w1 + {15'd0, v[16:0]}; n = 2; end
      else begin
        pa_pte = w1 + {24'd0, v[16:11], 2'b00};
        ea[2] = pa_pte;
        pte = mem_rd(pa_pte);
        n = 3;
        if (!pte[0]) begin f = 1'b1; code = 2'd3; end
        else pa = {pte[31:11], v[10:0]};
      end
    end
  endtask

  task automatic run(input logic [31:0] v, input bit spurious);
    logic f; logic [1:0] code; logic [31:0] pa; int n; logic [31:0] ea [4];
    int k;
    model(v, f, code, pa, n, ea);
    nrd = 0;
    @(negedge clk);
    req_i = 1'b1; vaddr_i = v;
    k = 0;
    do begin
      @(negedge clk);
      if (k == 0 && spurious) begin req_i = 1'b1; vaddr_i = ~v; end
      else begin req_i = 1'b0; vaddr_i = '0; end
      k++;
    end while (!valid_o && k < 60);
    if (!valid_o) begin
      checks++; fails++;
      $display("FAIL R8: no completion for %h got valid 0 expected 1", v);
      return;
    end
    chk("R8 ack-to-valid cycles", 32'(cyc - last_ack_cyc), 32'd1);
    chk("R3/R4/R6 fault flag", {31'd0, fault_o}, {31'd0, f});
    chk("R3/R4/R6 fault code", {30'd0, fault_code_o}, {30'd0, code});
    if (f) chk("R8 fault address", fault_addr_o, v);
    else   chk("R5/R7 physical address", paddr_o, pa);
    chk("R5/R7 read count", 32'(nrd), 32'(n));
    chk("R2 first read address", rd_log[0], ea[0]);
    if (n > 1) chk("R2 second read address", rd_log[1], ea[1]);
    if (n > 2) chk("R6 page entry address", rd_log[2], ea[2]);
    @(negedge clk);
    chk("R8/R9 single pulse, idle after", {29'd0, valid_o, busy_o, mem_req_o}, 32'd0);
  endtask

  initial begin
    #1ms;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    sb[0] = 32'h0001_0000; sb[1] = 32'h0002_0000;
    sb[2] = 32'h0003_0000; sb[3] = 32'h0004_0000;

    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 reset controls", {28'd0, busy_o, mem_req_o, valid_o, fault_o}, 32'd0);
    chk("R1 reset paddr", paddr_o, 32'd0);
    chk("R1 reset fault info", fault_addr_o | {30'd0, fault_code_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after release", {30'd0, busy_o, valid_o}, 32'd0);

    // R5 contiguous, full limit; R9 stray request while busy
    ovr[32'h0002_0028] = 32'h8001_FFFF;
    ovr[32'h0002_002C] = 32'h0100_0000;
    run({2'd1, 13'd5, 17'h1_2345}, 1'b1);
    chk("R5 directed contiguous", paddr_o, 32'h0101_2345);

    // R3 absent segment
    ovr[32'h0003_0038] = 32'h0000_0000;
    run({2'd2, 13'd7, 17'h0_0010}, 1'b0);
    chk("R3 directed absent code", {30'd0, fault_code_o}, 32'd1);

    // R4 limit: one past the limit faults, equal passes
    ovr[32'h0004_0008] = 32'h8000_0100;
    ovr[32'h0004_000C] = 32'h5000_0000;
    run({2'd3, 13'd1, 17'h0_0101}, 1'b0);
    chk("R4 over limit code", {30'd0, fault_code_o}, 32'd2);
    run({2'd3, 13'd1, 17'h0_0100}, 1'b1);
    chk("R4 at limit passes", paddr_o, 32'h5000_0100);

    // R6/R7 paged segment
    ovr[32'h0001_0048] = 32'hC001_FFFF;
    ovr[32'h0001_004C] = 32'h0080_0000;
    ovr[32'h0080_00A8] = 32'hABCD_E801;
    ovr[32'h0080_00FC] = 32'hFFFF_F800;
    run({2'd0, 13'd9, 6'h2A, 11'h7FF}, 1'b1);
    chk("R7 directed paged", paddr_o, 32'hABCD_EFFF);
    run({2'd0, 13'd9, 6'h3F, 11'h001}, 1'b1);
    chk("R6 page absent code", {30'd0, fault_code_o}, 32'd3);

    // random mix over hashed tables
    for (int i = 0; i < 300; i++) begin
      logic [31:0] v;
      v = $urandom;
      if ($urandom % 2 == 0) v[16:0] = v[16:0] & 17'h00FFF;
      run(v, 1'b0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule